// File: doc/BRIEF.md
# Latched Device Interrupt Aggregator

This block gathers the device-side interrupt events of a USB peripheral controller onto a single active-low interrupt output. Each event source raises a sticky status bit. Each status bit has its own enable bit. The enabled status bits are ORed together. The result drives the output pin through a hold stage. A global enable bit in a mode register opens or closes that stage. When the stage is closed, the pin keeps its last value, so an interrupt that is already signalled stays signalled.

Firmware reaches the block through a small synchronous register port with three registers:

- a status register, cleared by writing ones to it;
- an enable register, one bit per source;
- a mode register holding the global enable.

The event sources are bus reset, suspend, resume, frame start, transfer end, control endpoint out, control endpoint in, and a parameterised number of further endpoints (fourteen by default). Events arrive as one-cycle pulses, synchronous to the register clock.

Top module: `dev_irq_combiner`

## Requirements
- R1: After reset, the status, enable and mode registers read 0. `irq_n_o` is high and `reg_rdata_o` is 0.
- R2: A pulse on `evt_i[k]` sets status bit k at that clock edge. This happens whatever the enable and global-enable settings are. The bit positions are: bus reset 0, suspend 1, resume 2, frame start 3, transfer end 4, control out 5, control in 6, and endpoint j (j from 1) at bit 6+j.
- R3: At each clock edge where the global enable is 1, `irq_n_o` is loaded for the next cycle. It goes low if any status bit with its enable bit set was pending before that edge. Otherwise it goes high.
- R4: At each clock edge where the global enable is 0, `irq_n_o` keeps its value. New events and enable writes do not change it.
- R5: Suppose an enabled status bit is pending. The mode write that sets the global enable takes effect at edge t. Then `irq_n_o` is low from edge t+1.
- R6: Suppose `irq_n_o` is low and the global enable is cleared. `irq_n_o` stays low, even after the status bits are cleared, until the global enable is set again.
- R7: A write to the status register clears every status bit whose write-data bit is 1. Bits written with 0 are left unchanged.
- R8: If an event and a status clear for the same bit fall in the same cycle, the bit ends up set.
- R9: The enable register stores write-data bits [N_SRC-1:0] and reads them back. Higher bits read 0.
- R10: The register addresses are 0 for status, 1 for enable, 2 for mode (global enable in bit 0) and 3 unused. A read of address 3 returns 0, and a write to it changes nothing. Read data appears on `reg_rdata_o` one edge after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and event clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | N_SRC (21) | One-cycle event pulses, one per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W (32) | Write data |
| reg_rdata_o | output | DATA_W (32) | Registered read data |
| irq_n_o | output | 1 | Interrupt output, low = asserted |

## Verification
A wrong hold-stage value shows on `irq_n_o` in the cycle after the faulty edge. Because the stage freezes while the global enable is 0, a bad value there persists until firmware reopens it. That is why the bench checks the pin after every step, not only after event steps.

A status or enable bit that is stuck, lost or misplaced is seen in two ways:

- on the pin, one edge after the global enable is set while that source is enabled;
- on a status read, one edge after the read strobe.

The per-source sweep makes each bit position go through both of these paths.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    // Register addresses on the synchronous register port
    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_ENABLE = 2'd1,
        REG_MODE   = 2'd2,
        REG_SPARE  = 2'd3
    } regaddr_e;

    // Fixed source positions; extra endpoints follow SRC_FIRST_EP
    localparam int SRC_BUSRST   = 0;
    localparam int SRC_SUSPEND  = 1;
    localparam int SRC_RESUME   = 2;
    localparam int SRC_FRAME    = 3;
    localparam int SRC_XFER_END = 4;
    localparam int SRC_CTL_OUT  = 5;
    localparam int SRC_CTL_IN   = 6;
    localparam int SRC_FIRST_EP = 7;
    localparam int N_FIXED_SRC  = 7;

    localparam int MODE_GEN_BIT = 0;

endpackage

// File: rtl/irqagg_status_bank.sv
module irqagg_status_bank #(
    parameter int N_SRC = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] status_o
);

    typedef struct packed {
        logic [N_SRC-1:0] status;
    } bank_state_t;

    bank_state_t state_d, state_q;

    // Clear first, then set: a simultaneous event overrides the clear.
    always_comb begin
        state_d        = state_q;
        state_d.status = (state_q.status & ~clr_i) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_o = state_q.status;

    AST_EVT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((status_o & $past(evt_i)) == $past(evt_i)))
        else $error("event not recorded"); // R2

    AST_EVT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & clr_i)) |=> ((status_o & $past(evt_i & clr_i)) == $past(evt_i & clr_i)))
        else $error("clear overrode event"); // R8

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((status_o & $past(clr_i & ~evt_i)) == '0))
        else $error("write-one clear failed"); // R7

    AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ~$past(status_o) & ~$past(evt_i)) == '0))
        else $error("status bit set without event"); // R2

endmodule

// File: rtl/irqagg_mask_reduce.sv
module irqagg_mask_reduce #(
    parameter int N_SRC   = 21,
    parameter int GROUP_W = 4
) (
    input  logic [N_SRC-1:0] status_i,
    input  logic [N_SRC-1:0] enable_i,
    output logic             pend_o
);

    localparam int N_GRP = (N_SRC + GROUP_W - 1) / GROUP_W;
    localparam int PAD_W = N_GRP * GROUP_W;

    logic [N_SRC-1:0] masked;
    logic [PAD_W-1:0] padded;
    logic [N_GRP-1:0] grp_any;

    assign masked = status_i & enable_i;

    always_comb begin
        padded              = '0;
        padded[N_SRC-1:0]   = masked;
    end

    // First level: small OR groups, second level: OR of the group results
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign grp_any[g] = |padded[g*GROUP_W +: GROUP_W];
    end

    assign pend_o = |grp_any;

endmodule

// File: rtl/irqagg_pin_hold.sv
module irqagg_pin_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic gen_i,
    input  logic pend_i,
    output logic irq_n_o
);

    typedef struct packed {
        logic asserted;
    } pin_state_t;

    pin_state_t state_d, state_q;

    // Clocked stand-in for a transparent latch: loads only while open.
    always_comb begin
        state_d = state_q;
        if (gen_i) begin
            state_d.asserted = pend_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_n_o = ~state_q.asserted;

    AST_RESET_DEASSERTED: assert property (@(posedge clk)
        $rose(rst_n) |-> irq_n_o)
        else $error("pin asserted out of reset"); // R1

    AST_PIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_i |=> $stable(irq_n_o))
        else $error("pin moved while stage closed"); // R4

    AST_PIN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        gen_i |=> (irq_n_o == !$past(pend_i)))
        else $error("pin did not follow pending"); // R3

endmodule

// File: rtl/irqagg_regport.sv
module irqagg_regport
    import irqagg_pkg::*;
#(
    parameter int N_SRC  = 21,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N_SRC-1:0]  status_i,
    output logic [N_SRC-1:0]  clr_o,
    output logic [N_SRC-1:0]  enable_o,
    output logic              gen_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic [N_SRC-1:0]  enable;
        logic              gen;
        logic [DATA_W-1:0] rdata;
    } port_state_t;

    port_state_t state_d, state_q;
    regaddr_e    sel;
    logic [DATA_W-1:0] rd_mux;
    logic        unused_wdata;

    assign sel          = regaddr_e'(addr_i);
    assign unused_wdata = ^wdata_i;

    // Status clear strobes
    always_comb begin
        clr_o = '0;
        if (wr_i && sel == REG_STATUS) begin
            clr_o = wdata_i[N_SRC-1:0];
        end
    end

    // Read selection
    always_comb begin
        rd_mux = '0;
        unique case (sel)
            REG_STATUS: rd_mux[N_SRC-1:0]    = status_i;
            REG_ENABLE: rd_mux[N_SRC-1:0]    = state_q.enable;
            REG_MODE:   rd_mux[MODE_GEN_BIT] = state_q.gen;
            default:    rd_mux               = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            unique case (sel)
                REG_ENABLE: state_d.enable = wdata_i[N_SRC-1:0];
                REG_MODE:   state_d.gen    = wdata_i[MODE_GEN_BIT];
                default:    ;
            endcase
        end
        if (rd_i) begin
            state_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign enable_o = state_q.enable;
    assign gen_o    = state_q.gen;
    assign rdata_o  = state_q.rdata;

    AST_SPARE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == 2'd3) |=> ($stable(enable_o) && $stable(gen_o)))
        else $error("spare write altered state"); // R10

    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == 2'd2) |=> (gen_o == $past(wdata_i[0])))
        else $error("mode write lost"); // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o))
        else $error("read data moved without read"); // R10

    AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == 2'd1) |=> (enable_o == $past(wdata_i[N_SRC-1:0])))
        else $error("enable write lost"); // R9

endmodule

// File: rtl/dev_irq_combiner.sv
module dev_irq_combiner
    import irqagg_pkg::*;
#(
    parameter  int N_EP    = 14,
    parameter  int DATA_W  = 32,
    parameter  int GROUP_W = 4,
    localparam int N_SRC   = N_FIXED_SRC + N_EP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  evt_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_n_o
);

    logic [N_SRC-1:0] status;
    logic [N_SRC-1:0] clr;
    logic [N_SRC-1:0] enable;
    logic             gen;
    logic             pend;

    irqagg_regport #(
        .N_SRC  (N_SRC),
        .DATA_W (DATA_W)
    ) u_regport (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr_i),
        .rd_i     (reg_rd_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .status_i (status),
        .clr_o    (clr),
        .enable_o (enable),
        .gen_o    (gen),
        .rdata_o  (reg_rdata_o)
    );

    irqagg_status_bank #(
        .N_SRC (N_SRC)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_i    (clr),
        .status_o (status)
    );

    irqagg_mask_reduce #(
        .N_SRC   (N_SRC),
        .GROUP_W (GROUP_W)
    ) u_reduce (
        .status_i (status),
        .enable_i (enable),
        .pend_o   (pend)
    );

    irqagg_pin_hold u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .gen_i   (gen),
        .pend_i  (pend),
        .irq_n_o (irq_n_o)
    );

    AST_CLOSED_NO_NEW_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen && irq_n_o) |=> irq_n_o)
        else $error("event reached pin while closed"); // R4

endmodule

// File: tb/dev_irq_combiner_bench.sv
module dev_irq_combiner_bench;

    localparam int NS = 21;
    localparam logic [31:0] EN_MASK = 32'h001F_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] evt = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [1:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    dev_irq_combiner u_dev_irq_combiner (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_n_o     (irq_n)
    );

    // Reference model written from the requirements
    logic [NS-1:0] m_stat, m_en;
    logic          m_gen, m_pin;
    logic [31:0]   m_rdata;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stat <= '0; m_en <= '0; m_gen <= 1'b0; m_pin <= 1'b0; m_rdata <= '0;
        end else begin
            if (m_gen) m_pin <= |(m_stat & m_en);
            m_stat <= (m_stat & ~((wr && addr == 2'd0) ? wdata[NS-1:0] : '0)) | evt;
            if (wr && addr == 2'd1) m_en  <= wdata[NS-1:0];
            if (wr && addr == 2'd2) m_gen <= wdata[0];
            if (rd) begin
                case (addr)
                    2'd0:    m_rdata <= {11'b0, m_stat};
                    2'd1:    m_rdata <= {11'b0, m_en};
                    2'd2:    m_rdata <= {31'b0, m_gen};
                    default: m_rdata <= '0;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive after negedge, let one edge pass, return at next negedge
    task automatic step(input logic w, input logic r, input logic [1:0] a,
                        input logic [31:0] d, input logic [NS-1:0] e);
        wr = w; rd = r; addr = a; wdata = d; evt = e;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0; rd = 1'b0; evt = '0;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 2'd0, 32'd0, '0);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        step(1'b1, 1'b0, a, d, '0);
    endtask

    task automatic rreg(input logic [1:0] a);
        step(1'b0, 1'b1, a, 32'd0, '0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pin", {31'b0, irq_n}, 32'd1);
        chk("R1 rdata", rdata, 32'd0);
        for (int a = 0; a < 3; a++) begin
            rreg(2'(a));
            chk("R1 reg", rdata, 32'd0);
        end

        // Per-source sweep
        for (int i = 0; i < NS; i++) begin
            logic [31:0] bit_i;
            bit_i = 32'd1 << i;
            wreg(2'd2, 32'd0);
            wreg(2'd1, 32'd0);
            chk("R4 idle", {31'b0, irq_n}, 32'd1);
            step(1'b0, 1'b0, 2'd0, 32'd0, bit_i[NS-1:0]);
            chk("R4 event closed", {31'b0, irq_n}, 32'd1);
            rreg(2'd0);
            chk("R2 status bit", rdata, bit_i);
            wreg(2'd1, bit_i);
            chk("R4 enable closed", {31'b0, irq_n}, 32'd1);
            wreg(2'd2, 32'd1);
            chk("R5 gen edge", {31'b0, irq_n}, 32'd1);
            idle();
            chk("R5 asserted", {31'b0, irq_n}, 32'd0);
            wreg(2'd2, 32'd0);
            chk("R6 gen cleared", {31'b0, irq_n}, 32'd0);
            wreg(2'd0, bit_i);
            chk("R6 status cleared", {31'b0, irq_n}, 32'd0);
            rreg(2'd0);
            chk("R7 cleared", rdata, 32'd0);
            chk("R6 still held", {31'b0, irq_n}, 32'd0);
            wreg(2'd2, 32'd1);
            chk("R6 reopen edge", {31'b0, irq_n}, 32'd0);
            idle();
            chk("R3 deasserted", {31'b0, irq_n}, 32'd1);
            step(1'b1, 1'b0, 2'd0, bit_i, bit_i[NS-1:0]);
            chk("R8 same edge", {31'b0, irq_n}, 32'd1);
            idle();
            chk("R8 pin", {31'b0, irq_n}, 32'd0);
            wreg(2'd0, ~bit_i);
            rreg(2'd0);
            chk("R8 status kept", rdata, bit_i);
            wreg(2'd0, 32'd0);
            rreg(2'd0);
            chk("R7 zero write", rdata, bit_i);
            wreg(2'd0, bit_i);
            chk("R3 clear edge", {31'b0, irq_n}, 32'd0);
            idle();
            chk("R3 released", {31'b0, irq_n}, 32'd1);
        end

        // R9 enable storage and width
        wreg(2'd1, 32'hFFFF_FFFF);
        rreg(2'd1);
        chk("R9 enable read", rdata, EN_MASK);
        // R10 spare address
        wreg(2'd3, 32'hFFFF_FFFF);
        rreg(2'd3);
        chk("R10 spare read", rdata, 32'd0);
        rreg(2'd1);
        chk("R10 enable untouched", rdata, EN_MASK);
        rreg(2'd2);
        chk("R10 mode read", rdata, 32'd1);
        idle();
        chk("R10 rdata hold", rdata, 32'd1);

        // Mixed random phase against the requirement model
        for (int k = 0; k < 4000; k++) begin
            int op;
            logic [NS-1:0] e;
            logic [31:0]   d;
            op = int'($urandom % 8);
            e  = NS'($urandom & $urandom & $urandom);
            d  = $urandom;
            case (op)
                0, 1:    step(1'b0, 1'b0, 2'd0, 32'd0, e);
                2:       step(1'b1, 1'b0, 2'd0, d & $urandom, e);
                3:       step(1'b1, 1'b0, 2'd1, d, e);
                4:       step(1'b1, 1'b0, 2'd2, {31'b0, d[0]}, e);
                5:       step(1'b1, 1'b1, 2'(d[3:2]), d, e);
                default: step(1'b0, 1'b1, 2'(d[1:0]), 32'd0, e);
            endcase
            chk("R3 model pin", {31'b0, irq_n}, {31'b0, ~m_pin});
            chk("R10 model rdata", rdata, m_rdata);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule